// File: doc/BRIEF.md
# Earliest-Timestamp Event Merger

This block merges fixed-length event packets held in several front-end input FIFOs into a single stream ordered by time. Every packet is six 16-bit words. The block forms a 40-bit ordering key for the packet at the head of each FIFO. A combinational comparator tree then finds the earliest eligible head. A selection stage latches the index of the winning source and replays that packet word by word from its own FIFO onto a valid/ready output. After the last word is accepted, the block spends one cycle re-running the comparison and then selects again.

The input FIFOs are outside the block. Each FIFO is first-word-fall-through. It reports its fill level in words, its head word, and the words at head offsets 3, 4 and 5, so the key can be read without consuming anything. The block pops one word at a time with a one-cycle pop strobe. With a ready sink, one packet leaves every seven cycles. At a 250 MHz clock this is about 35.7 million events per second, above the 20 million required.

Top module: `emg_merge`

## Requirements
- R1: While rst_ni is low, out_valid_o is low and fifo_pop_o is all zero.
- R2: A source is eligible only when its level fifo_lvl_i is 6 or more words. Sources with a partial packet are never selected. When no source is eligible, out_valid_o stays low.
- R3: The key of a source is {word 3, word 4, bits 7:0 of word 5} of its head packet, with word 3 as the most significant part. The earliest eligible key is selected, and out_src_o gives its source index.
- R4: When two or more eligible sources have equal keys, the lowest source index wins.
- R5: A selected packet leaves as six words in FIFO order, word 0 first, without alteration. out_last_o is high on the sixth word only.
- R6: fifo_pop_o is one-hot at the selected source exactly in the cycles where out_valid_o and out_ready_i are both high, and zero otherwise. While the output is stalled, out_data_o and out_src_o hold.
- R7: After the last word is accepted, out_valid_o is low for exactly one cycle, and the next selection is made in that cycle. With out_ready_i held high, a packet leaves every 7 cycles.
- R8: The source index stays latched for the whole packet, even if another source becomes eligible with an earlier key in the meantime.
- R9: When every packet is already queued and each FIFO holds its packets in non-decreasing key order, the merged output leaves in non-decreasing key order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_lvl_i | input | N_SRC*LVL_W | Per-source FIFO fill level in words |
| fifo_head_i | input | N_SRC*16 | Per-source head word (first-word-fall-through) |
| fifo_w3_i | input | N_SRC*16 | Per-source word at head offset 3 |
| fifo_w4_i | input | N_SRC*16 | Per-source word at head offset 4 |
| fifo_w5_i | input | N_SRC*16 | Per-source word at head offset 5 |
| fifo_pop_o | output | N_SRC | Per-source pop strobe, one word per cycle |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Sink accepts the word |
| out_data_o | output | 16 | Output word |
| out_last_o | output | 1 | Marks the sixth word of a packet |
| out_src_o | output | 4 | Source index of the packet being sent |

## Verification
Two events can land in the same cycle: the final pop of the packet being sent, and a word pushed into another FIFO (or the same one) that completes a new packet there. The comparison in the idle cycle that follows must take both the shrunken level and the newly complete packet into account. The bench provokes this by trickling words into every FIFO at random while the sink stalls at random, so pushes fall on last beats many times. A behavioural queue model predicts the valid, data, last, source and pop values every cycle and compares them. Separate phases force ties on equal keys and a packet that stays partial for many cycles.

// File: rtl/emg_pkg.sv
package emg_pkg;
  localparam int WORD_W    = 16;
  localparam int TS_W      = 40;
  localparam int FRAC_W    = 8;
  localparam int IDX_W     = 4;
  localparam int MAX_SRC   = 1 << IDX_W;
  localparam int PKT_WORDS = 6;
  localparam int BEAT_W    = $clog2(PKT_WORDS);

  typedef struct packed {
    logic              vld;
    logic [IDX_W-1:0]  idx;
    logic [TS_W-1:0]   ts;
  } cand_t;

  // a beats b: valid, earlier key, or equal key with lower index
  function automatic logic a_wins(cand_t a, cand_t b);
    if (!a.vld) return 1'b0;
    if (!b.vld) return 1'b1;
    if (a.ts != b.ts) return a.ts < b.ts;
    return a.idx <= b.idx;
  endfunction
endpackage

// File: rtl/emg_key_extract.sv
module emg_key_extract
  import emg_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 8
) (
  input  logic [N_SRC*LVL_W-1:0]  fifo_lvl_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_w3_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_w4_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_w5_i,
  output cand_t                   cand_o [N_SRC]
);
  localparam logic [LVL_W-1:0] MIN_LVL = LVL_W'(PKT_WORDS);

  for (genvar j = 0; j < N_SRC; j++) begin : g_src
    logic [LVL_W-1:0]  lvl;
    logic [WORD_W-1:0] w3, w4, w5;
    assign lvl = fifo_lvl_i[j*LVL_W +: LVL_W];
    assign w3  = fifo_w3_i[j*WORD_W +: WORD_W];
    assign w4  = fifo_w4_i[j*WORD_W +: WORD_W];
    assign w5  = fifo_w5_i[j*WORD_W +: WORD_W];
    always_comb begin
      cand_o[j].vld = lvl >= MIN_LVL;
      cand_o[j].idx = IDX_W'(j);
      cand_o[j].ts  = {w3, w4, w5[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/emg_cmp_node.sv
module emg_cmp_node
  import emg_pkg::*;
(
  input  cand_t a_i,
  input  cand_t b_i,
  output cand_t y_o
);
  assign y_o = a_wins(a_i, b_i) ? a_i : b_i;
endmodule

// File: rtl/emg_cmp_tree.sv
module emg_cmp_tree
  import emg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  cand_t cand_i [N_SRC],
  output cand_t win_o
);
  localparam int LEAVES = 1 << $clog2(N_SRC);
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  // leaves; padding slots never valid
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_SRC) begin : g_real
      assign node[LEAVES-1+j] = cand_i[j];
    end else begin : g_pad
      assign node[LEAVES-1+j] = '{vld: 1'b0, idx: IDX_W'(j), ts: '0};
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    emg_cmp_node u_node (
      .a_i (node[2*i+1]),
      .b_i (node[2*i+2]),
      .y_o (node[i])
    );
  end

  assign win_o = node[0];
endmodule

// File: rtl/emg_pkt_seq.sv
module emg_pkt_seq
  import emg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  cand_t                   win_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_head_i,
  output logic [N_SRC-1:0]        fifo_pop_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [WORD_W-1:0]       out_data_o,
  output logic                    out_last_o,
  output logic [IDX_W-1:0]        out_src_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PKT_WORDS - 1);

  typedef enum logic {ST_PICK, ST_SEND} st_e;

  st_e               st_q;
  logic [IDX_W-1:0]  sel_q;
  logic [BEAT_W-1:0] beat_q;
  logic              fire, at_last;

  assign fire    = (st_q == ST_SEND) && out_ready_i;
  assign at_last = beat_q == LAST_BEAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PICK;
      sel_q  <= '0;
      beat_q <= '0;
    end else begin
      case (st_q)
        ST_PICK: if (win_i.vld) begin
          sel_q  <= win_i.idx;
          beat_q <= '0;
          st_q   <= ST_SEND;
        end
        ST_SEND: if (fire) begin
          if (at_last) st_q <= ST_PICK;
          else         beat_q <= beat_q + 1'b1;
        end
        default: st_q <= ST_PICK;
      endcase
    end
  end

  logic [WORD_W-1:0] head [N_SRC];
  for (genvar j = 0; j < N_SRC; j++) begin : g_head
    assign head[j]       = fifo_head_i[j*WORD_W +: WORD_W];
    assign fifo_pop_o[j] = fire && (sel_q == IDX_W'(j));
  end

  always_comb begin
    out_data_o = '0;
    for (int j = 0; j < N_SRC; j++) begin
      if (sel_q == IDX_W'(j)) out_data_o = head[j];
    end
  end

  assign out_valid_o = st_q == ST_SEND;
  assign out_last_o  = (st_q == ST_SEND) && at_last;
  assign out_src_o   = sel_q;
endmodule

// File: rtl/emg_merge.sv
module emg_merge
  import emg_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC*LVL_W-1:0]  fifo_lvl_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_head_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_w3_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_w4_i,
  input  logic [N_SRC*WORD_W-1:0] fifo_w5_i,
  output logic [N_SRC-1:0]        fifo_pop_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [WORD_W-1:0]       out_data_o,
  output logic                    out_last_o,
  output logic [IDX_W-1:0]        out_src_o
);
  cand_t cand [N_SRC];
  cand_t win;

  emg_key_extract #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_key (
    .fifo_lvl_i (fifo_lvl_i),
    .fifo_w3_i  (fifo_w3_i),
    .fifo_w4_i  (fifo_w4_i),
    .fifo_w5_i  (fifo_w5_i),
    .cand_o     (cand)
  );

  emg_cmp_tree #(.N_SRC(N_SRC)) u_tree (
    .cand_i (cand),
    .win_o  (win)
  );

  emg_pkt_seq #(.N_SRC(N_SRC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .win_i       (win),
    .fifo_head_i (fifo_head_i),
    .fifo_pop_o  (fifo_pop_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .out_src_o   (out_src_o)
  );
endmodule

// File: rtl/emg_merge_chk.sv
module emg_merge_chk
  import emg_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC*LVL_W-1:0]  fifo_lvl_i,
  input logic [N_SRC-1:0]        fifo_pop_o,
  input logic                    out_valid_o,
  input logic                    out_ready_i,
  input logic [WORD_W-1:0]       out_data_o,
  input logic                    out_last_o,
  input logic [IDX_W-1:0]        out_src_o
);
  logic       fire;
  logic [2:0] beats;
  logic [LVL_W-1:0] src_lvl;

  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                beats <= '0;
    else if (fire && out_last_o) beats <= '0;
    else if (fire)              beats <= beats + 3'd1;
  end

  always_comb begin
    src_lvl = '0;
    for (int j = 0; j < N_SRC; j++)
      if (out_src_o == IDX_W'(j)) src_lvl = fifo_lvl_i[j*LVL_W +: LVL_W];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && fifo_pop_o == '0));

  assert_eligible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> src_lvl >= LVL_W'(PKT_WORDS));

  assert_src_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> 32'(out_src_o) < N_SRC);

  assert_last_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (beats == 3'd5)));

  assert_pop_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fifo_pop_o));

  assert_pop_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fifo_pop_o) == fire);

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_src_o)));

  assert_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && out_last_o) |=> !out_valid_o);

  assert_src_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !(fire && out_last_o)) |=> (out_valid_o && $stable(out_src_o)));
endmodule

bind emg_merge emg_merge_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_lvl_i  (fifo_lvl_i),
  .fifo_pop_o  (fifo_pop_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_src_o   (out_src_o)
);

// File: tb/emg_merge_test.sv
module emg_merge_test;
  localparam int N  = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N*LW-1:0] lvl;
  logic [N*16-1:0] head, w3, w4, w5;
  logic [N-1:0]    pop;
  logic            ov, ordy, olast;
  logic [15:0]     od;
  logic [3:0]      osrc;

  emg_merge #(.N_SRC(N), .LVL_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_lvl_i(lvl), .fifo_head_i(head),
    .fifo_w3_i(w3), .fifo_w4_i(w4), .fifo_w5_i(w5), .fifo_pop_o(pop),
    .out_valid_o(ov), .out_ready_i(ordy), .out_data_o(od),
    .out_last_o(olast), .out_src_o(osrc)
  );

  logic [15:0] fq   [N][$];
  logic [15:0] pend [N][$];
  logic [15:0] sent [N][$];
  logic [15:0] got  [N][$];
  logic [39:0] cur_ts [N];
  int src_log [$];

  int vec = 0, err = 0;
  bit done = 0;
  bit m_busy = 0, fire_prev = 0, order_on = 0;
  int m_sel = 0, m_beat = 0, pick_prev = -1;
  logic [39:0] last_key = '0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (!ok) begin
      err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] key(int s);
    return {fq[s][3], fq[s][4], fq[s][5][7:0]};
  endfunction

  // earliest complete packet, lowest index on ties
  function automatic int pick();
    int best = -1;
    for (int s = 0; s < N; s++)
      if (fq[s].size() >= 6)
        if (best < 0 || key(s) < key(best)) best = s;
    return best;
  endfunction

  task automatic drive();
    for (int s = 0; s < N; s++) begin
      int n = fq[s].size();
      lvl[s*LW +: LW]  = LW'(n);
      head[s*16 +: 16] = n > 0 ? fq[s][0] : 16'h0;
      w3[s*16 +: 16]   = n > 3 ? fq[s][3] : 16'h0;
      w4[s*16 +: 16]   = n > 4 ? fq[s][4] : 16'h0;
      w5[s*16 +: 16]   = n > 5 ? fq[s][5] : 16'h0;
    end
  endtask

  task automatic make_pkt(int s, logic [39:0] ts, bit direct);
    logic [15:0] w [6];
    w[0] = 16'($urandom); w[1] = 16'($urandom); w[2] = 16'($urandom);
    w[3] = ts[39:24]; w[4] = ts[23:8]; w[5] = {8'($urandom), ts[7:0]};
    for (int k = 0; k < 6; k++) begin
      sent[s].push_back(w[k]);
      if (direct) fq[s].push_back(w[k]);
      else pend[s].push_back(w[k]);
    end
  endtask

  task automatic step(int ready_pct, int push_pct);
    @(negedge clk);
    if (fire_prev) begin
      void'(fq[m_sel].pop_front());
      m_beat++;
      if (m_beat == 6) m_busy = 0;
    end else if (!m_busy && pick_prev >= 0) begin
      m_busy = 1; m_sel = pick_prev; m_beat = 0;
      src_log.push_back(m_sel);
      if (order_on) begin
        // R9 global ordering
        chk(key(m_sel) >= last_key, "R9", "key order", 64'(key(m_sel)), 64'(last_key));
        last_key = key(m_sel);
      end
    end
    for (int s = 0; s < N; s++)
      if (pend[s].size() > 0 && $urandom_range(99) < push_pct)
        fq[s].push_back(pend[s].pop_front());
    ordy = $urandom_range(99) < ready_pct;
    drive();
    #1;
    chk(ov == m_busy, "R2/R7", "out_valid", 64'(ov), 64'(m_busy));
    if (m_busy) begin
      chk(od == fq[m_sel][0], "R5", "out_data", 64'(od), 64'(fq[m_sel][0]));
      chk(olast == (m_beat == 5), "R5", "out_last", 64'(olast), 64'(m_beat == 5));
      chk(osrc == 4'(m_sel), "R3/R4/R8", "out_src", 64'(osrc), 64'(m_sel));
    end
    begin
      logic [N-1:0] ep = (m_busy && ordy) ? N'(1) << m_sel : '0;
      chk(pop == ep, "R6", "fifo_pop", 64'(pop), 64'(ep));
    end
    fire_prev = m_busy && ordy;
    if (fire_prev) got[m_sel].push_back(od);
    pick_prev = m_busy ? -1 : pick();
  endtask

  function automatic bit drained();
    if (m_busy || fire_prev || pick_prev >= 0) return 0;
    for (int s = 0; s < N; s++)
      if (fq[s].size() != 0 || pend[s].size() != 0) return 0;
    return 1;
  endfunction

  task automatic run_until_drained(int ready_pct, int push_pct);
    do step(ready_pct, push_pct); while (!drained());
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      err++; vec++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    ordy = 1'b0;
    drive();
    // R1 reset behaviour
    repeat (3) begin
      @(negedge clk); #1;
      chk(ov == 1'b0, "R1", "out_valid in reset", 64'(ov), 64'h0);
      chk(pop == '0, "R1", "pop in reset", 64'(pop), 64'h0);
    end
    // queue a packet before release so reset must block it
    make_pkt(1, 40'h10, 1'b1);
    drive();
    @(negedge clk); #1;
    chk(ov == 1'b0, "R1", "out_valid in reset, pkt queued", 64'(ov), 64'h0);
    rst_n = 1'b1;
    pick_prev = pick();
    run_until_drained(100, 0);

    // R2 idle with empty FIFOs, then partial packet
    repeat (10) step(100, 0);
    for (int k = 0; k < 5; k++) begin
      logic [15:0] w = 16'(k + 16'h50);
      sent[2].push_back(w); fq[2].push_back(w);
    end
    repeat (15) step(100, 0);
    chk(got[2].size() == 0, "R2", "partial packet output", 64'(got[2].size()), 64'h0);
    sent[2].push_back(16'h0055); fq[2].push_back(16'h0055);
    run_until_drained(100, 0);

    // R4 ties: same key in all sources; R7 cadence at full ready
    src_log.delete();
    for (int s = N - 1; s >= 0; s--) make_pkt(s, 40'h500, 1'b1);
    run_until_drained(100, 0);
    for (int s = 0; s < N; s++)
      chk(src_log[s] == s, "R4", "tie order", 64'(src_log[s]), 64'(s));

    // R9 preloaded random streams, random stalls
    for (int s = 0; s < N; s++) cur_ts[s] = 40'h1000;
    for (int p = 0; p < 20; p++)
      for (int s = 0; s < N; s++) begin
        cur_ts[s] = cur_ts[s] + 40'($urandom_range(3));
        make_pkt(s, cur_ts[s], 1'b1);
      end
    order_on = 1; last_key = '0;
    run_until_drained(70, 0);
    order_on = 0;

    // R8 trickled arrivals: pushes coincide with last beats
    for (int p = 0; p < 15; p++)
      for (int s = 0; s < N; s++) begin
        cur_ts[s] = cur_ts[s] + 40'($urandom_range(5));
        make_pkt(s, cur_ts[s], 1'b0);
      end
    run_until_drained(75, 40);

    // R5 every packet exactly once, unaltered
    for (int s = 0; s < N; s++) begin
      chk(got[s].size() == sent[s].size(), "R5", "word count", 64'(got[s].size()), 64'(sent[s].size()));
      if (got[s].size() == sent[s].size())
        for (int k = 0; k < sent[s].size(); k++)
          if (got[s][k] != sent[s][k]) begin
            chk(1'b0, "R5", "packet word", 64'(got[s][k]), 64'(sent[s][k]));
            break;
          end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule